// File: doc/BRIEF.md
# Internal Data RAM Window Controller

This block sits between an 8-bit CPU core and the external data memory path. Every external-data read or write the core issues passes through it. When the internal RAM is enabled, an access whose address falls in the top 256 bytes of the 64 KB data space (FF00H to FFFFH) is served by an on-chip RAM. Any other access is handed to the external bus engine with a one-cycle request. Read data comes back in the cycle after the request, whether it came from the RAM or from the external bus.

A control register at special-function address B1H holds two bits:

- The **lock bit** (bit 0) disables the internal RAM when it is 1. It resets to 1. A plain write cannot change it. It can change only on a write that lands in the cycle right after the key pair 0xAA, 0x55 has been written to the register in consecutive cycles.
- The **show bit** (bit 1), when set, mirrors internal accesses onto the external bus. The strobes go active and the address and data being transferred are driven on the port pins, so internal traffic can be observed.

Top module: `xram_gate`

## Requirements
- R1: After reset, a read of register address B1H returns 0x21: lock bit (bit 0) = 1, show bit (bit 1) = 0, bits 5:4 = 2'b10. While locked, every access produces ext_req.
- R2: While the lock bit is 1, every read or write raises ext_req in the same cycle, including addresses FF00H–FFFFH. The matching strobe, ext_rd_stb or ext_wr_stb, is asserted. ext_drive_visible stays 0.
- R3: A write to B1H outside the unlock slot updates bit 1 and bits 5:4 from the write data and leaves bit 0 unchanged. Bits 7:6 and 3:2 always read as 0.
- R4: After a write of 0xAA and then a write of 0x55 to B1H in consecutive cycles, a write to B1H in the very next cycle loads bit 0 from data bit 0.
- R5: The key sequence fails, and bit 0 is left unchanged, if there is an idle cycle between the key writes or if the keys are written in the wrong order.
- R6: With the lock bit 0 and the show bit 0, an access whose address high byte is FFH uses the internal RAM. ext_req, both strobes and ext_drive_visible stay 0. A read returns the last byte written to that address on mem_rdata one cycle later.
- R7: An access routed to the external bus asserts ext_req for that cycle only. ext_addr_hi and ext_addr_lo carry the address. A write drives its data with ext_data_oe = 1. A read returns the ext_data_in value from the request cycle on mem_rdata one cycle later.
- R8: With the lock bit 0 and the show bit 1, an internal access asserts ext_drive_visible and the matching strobe, drives the address on the ports, and drives on ext_data_out either the write data or the RAM byte being read. A read still returns the RAM byte, and ext_data_in is ignored.
- R9: The show bit has no effect on accesses outside the window or while the lock bit is 1. Those accesses behave as in R2 or R7, and ext_drive_visible stays 0.
- R10: A register read at any address other than B1H returns 0. A write at such an address changes no bit of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| mem_rd | input | 1 | External-data read request, one cycle |
| mem_wr | input | 1 | External-data write request, one cycle |
| mem_addr | input | 16 | Access address |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Read data, valid the cycle after mem_rd |
| ext_data_in | input | 8 | Data sampled from the external bus |
| ext_req | output | 1 | Access is routed to the external bus |
| ext_rd_stb | output | 1 | External read strobe |
| ext_wr_stb | output | 1 | External write strobe |
| ext_addr_lo | output | 8 | Low address byte on the port |
| ext_addr_hi | output | 8 | High address byte on the port |
| ext_data_out | output | 8 | Data driven on the port |
| ext_data_oe | output | 1 | Port data drive enable |
| ext_drive_visible | output | 1 | Internal access mirrored onto the port |

## Verification
The assertions assume that mem_rd and mem_wr are never high in the same cycle. They also assume that each request lasts exactly one cycle, with address and data held steady for that cycle. The bench raises one request at a time from a negative edge, holds it for exactly one clock, and changes register state only through single-cycle writes. This keeps the mirrored-bus and external-request properties within those input conditions.

// File: rtl/xram_gate.sv
module xram_gate #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LOW_BITS = 8,
  parameter logic [7:0] CTL_ADDR = 8'hB1,
  parameter logic [7:0] KEY_A = 8'hAA,
  parameter logic [7:0] KEY_B = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfr_wr,
  input  logic [7:0]    sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] ext_data_in,
  output logic          ext_req,
  output logic          ext_rd_stb,
  output logic          ext_wr_stb,
  output logic [7:0]    ext_addr_lo,
  output logic [AW-9:0] ext_addr_hi,
  output logic [DW-1:0] ext_data_out,
  output logic          ext_data_oe,
  output logic          ext_drive_visible
);
  localparam int DEPTH = 1 << LOW_BITS;

  logic dis_q, vis_q, key1_q, key2_q;
  logic [1:0] aux_q;
  logic [DW-1:0] ram [DEPTH];

  wire ctl_sel = (sfr_addr == CTL_ADDR);
  wire ctl_wr  = sfr_wr & ctl_sel;
  wire unused_wdata = ^{sfr_wdata[7:6], sfr_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b1;
      vis_q  <= 1'b0;
      aux_q  <= 2'b10;
      key1_q <= 1'b0;
      key2_q <= 1'b0;
    end else begin
      key1_q <= ctl_wr && (sfr_wdata == KEY_A);
      key2_q <= ctl_wr && key1_q && (sfr_wdata == KEY_B);
      if (ctl_wr) begin
        vis_q <= sfr_wdata[1];
        aux_q <= sfr_wdata[5:4];
        if (key2_q) dis_q <= sfr_wdata[0];
      end
    end
  end

  assign sfr_rdata = ctl_sel ? {2'b00, aux_q, 2'b00, vis_q, dis_q} : 8'h00;

  wire [LOW_BITS-1:0] idx = mem_addr[LOW_BITS-1:0];
  wire access   = mem_rd | mem_wr;
  wire in_win   = &mem_addr[AW-1:LOW_BITS];
  wire hit      = in_win & ~dis_q;
  wire internal = access & hit;
  wire show     = internal & vis_q;
  wire bus_on   = ext_req | show;
  wire [DW-1:0] ram_q = ram[idx];

  assign ext_req           = access & ~hit;
  assign ext_drive_visible = show;
  assign ext_rd_stb        = mem_rd & bus_on;
  assign ext_wr_stb        = mem_wr & bus_on;
  assign ext_addr_lo       = bus_on ? mem_addr[7:0] : 8'h00;
  assign ext_addr_hi       = bus_on ? mem_addr[AW-1:8] : '0;
  assign ext_data_oe       = (mem_wr & bus_on) | (mem_rd & show);
  assign ext_data_out      = !ext_data_oe ? '0 : (mem_wr ? mem_wdata : ram_q);

  always_ff @(posedge clk) begin
    if (internal && mem_wr) ram[idx] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_rdata <= '0;
    else if (mem_rd) mem_rdata <= hit ? ram_q : ext_data_in;
  end
endmodule

// File: rtl/xram_gate_chk.sv
module xram_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sfr_wr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          ext_req,
  input logic          ext_rd_stb,
  input logic          ext_wr_stb,
  input logic          ext_drive_visible,
  input logic [DW-1:0] ext_data_in,
  input logic [DW-1:0] mem_rdata,
  input logic          dis_q,
  input logic          vis_q
);
  p_locked_goes_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && (mem_rd || mem_wr)) |-> ext_req);

  p_lock_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_wr |=> $stable(dis_q));

  p_hidden_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !ext_req && !vis_q) |-> (!ext_rd_stb && !ext_wr_stb));

  p_route_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !ext_drive_visible);

  p_ext_read_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && ext_req) |=> (mem_rdata == $past(ext_data_in)));

  p_show_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_drive_visible |-> (vis_q && !dis_q));
endmodule

bind xram_gate xram_gate_chk #(.DW(DW)) u_chk (.*);

// File: tb/xram_gate_bench.sv
module xram_gate_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic sfr_wr = 0;
  logic [7:0] sfr_addr = 8'hB1, sfr_wdata = 0, sfr_rdata;
  logic mem_rd = 0, mem_wr = 0;
  logic [15:0] mem_addr = 0;
  logic [7:0] mem_wdata = 0, mem_rdata, ext_data_in = 0;
  logic ext_req, ext_rd_stb, ext_wr_stb, ext_data_oe, ext_drive_visible;
  logic [7:0] ext_addr_lo, ext_addr_hi, ext_data_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_gate u_xram_gate (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic rd, wr;
    logic [15:0] addr;
    logic [7:0] wd, ein;
    logic xreq, rs, ws, vis;
    logic [7:0] rdat;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{2'b01, 1'b0, 1'b1, 16'hFF10, 8'h11, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    '{2'b01, 1'b1, 1'b0, 16'hFF10, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A},
    '{2'b00, 1'b0, 1'b1, 16'hFF10, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{2'b00, 1'b1, 1'b0, 16'hFF10, 8'h00, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    '{2'b00, 1'b0, 1'b1, 16'hFFFF, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{2'b00, 1'b1, 1'b0, 16'hFFFF, 8'h00, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3},
    '{2'b00, 1'b1, 1'b0, 16'hFEFF, 8'h00, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, 8'h77},
    '{2'b00, 1'b0, 1'b1, 16'h0000, 8'h44, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    '{2'b10, 1'b1, 1'b0, 16'hFF10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},
    '{2'b10, 1'b0, 1'b1, 16'hFF20, 8'h81, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},
    '{2'b10, 1'b1, 1'b0, 16'hFF20, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81},
    '{2'b10, 1'b1, 1'b0, 16'h1234, 8'h00, 8'h66, 1'b1, 1'b1, 1'b0, 1'b0, 8'h66},
    '{2'b11, 1'b1, 1'b0, 16'hFF20, 8'h00, 8'h2B, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2B}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sfr_cycle(logic w, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfr_wr = w; sfr_addr = a; sfr_wdata = d;
  endtask

  task automatic sfr_idle();
    sfr_cycle(1'b0, 8'hB1, 8'h00);
  endtask

  task automatic read_ctl(string req, logic [7:0] a, logic [7:0] exp);
    sfr_cycle(1'b0, a, 8'h00);
    #1 check(req, {8'h00, sfr_rdata}, {8'h00, exp});
  endtask

  task automatic set_ctl(logic [1:0] m);
    sfr_cycle(1'b1, 8'hB1, 8'hAA);
    sfr_cycle(1'b1, 8'hB1, 8'h55);
    sfr_cycle(1'b1, 8'hB1, {6'b001000, m});
    sfr_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_ctl("R1 reset value", 8'hB1, 8'h21);
    @(negedge clk);
    mem_rd = 1; mem_addr = 16'hFF00;
    #1 check("R1 locked after reset", {15'd0, ext_req}, 16'd1);
    @(negedge clk); mem_rd = 0;

    sfr_cycle(1'b1, 8'hB1, 8'hFE); sfr_idle();
    read_ctl("R3 plain write keeps bit0, reserved zero", 8'hB1, 8'h33);
    sfr_cycle(1'b1, 8'hB1, 8'h10); sfr_idle();
    read_ctl("R3 bit1 and bits5:4 follow write", 8'hB1, 8'h11);

    sfr_cycle(1'b1, 8'hB2, 8'h22); sfr_idle();
    read_ctl("R10 foreign write ignored", 8'hB1, 8'h11);
    read_ctl("R10 foreign read zero", 8'hB2, 8'h00);

    sfr_cycle(1'b1, 8'hB1, 8'hAA); sfr_idle();
    sfr_cycle(1'b1, 8'hB1, 8'h55); sfr_cycle(1'b1, 8'hB1, 8'h20); sfr_idle();
    read_ctl("R5 gap between keys", 8'hB1, 8'h21);
    sfr_cycle(1'b1, 8'hB1, 8'h55); sfr_cycle(1'b1, 8'hB1, 8'hAA);
    sfr_cycle(1'b1, 8'hB1, 8'h20); sfr_idle();
    read_ctl("R5 keys reversed", 8'hB1, 8'h21);

    set_ctl(2'b00);
    read_ctl("R4 unlock clears bit0", 8'hB1, 8'h20);
    sfr_cycle(1'b1, 8'hB1, 8'h21); sfr_idle();
    read_ctl("R4 later plain write cannot relock", 8'hB1, 8'h20);
    set_ctl(2'b01);
    read_ctl("R4 unlock sets bit0", 8'hB1, 8'h21);

    foreach (VEC[i]) begin
      set_ctl(VEC[i].mode);
      @(negedge clk);
      mem_rd = VEC[i].rd; mem_wr = VEC[i].wr; mem_addr = VEC[i].addr;
      mem_wdata = VEC[i].wd; ext_data_in = VEC[i].ein;
      #1;
      check($sformatf("R2/R6/R7/R8/R9 vec%0d req", i), {15'd0, ext_req}, {15'd0, VEC[i].xreq});
      check($sformatf("R2/R6/R7/R8 vec%0d strobes", i), {14'd0, ext_rd_stb, ext_wr_stb},
            {14'd0, VEC[i].rs, VEC[i].ws});
      check($sformatf("R8/R9 vec%0d visible", i), {15'd0, ext_drive_visible}, {15'd0, VEC[i].vis});
      if (VEC[i].rs || VEC[i].ws)
        check($sformatf("R7/R8 vec%0d address", i), {ext_addr_hi, ext_addr_lo}, VEC[i].addr);
      if (VEC[i].ws)
        check($sformatf("R7/R8 vec%0d write data", i), {7'd0, ext_data_oe, ext_data_out},
              {8'h01, VEC[i].wd});
      if (VEC[i].rs && VEC[i].vis)
        check($sformatf("R8 vec%0d mirrored read data", i), {7'd0, ext_data_oe, ext_data_out},
              {8'h01, VEC[i].rdat});
      @(posedge clk);
      #1;
      mem_rd = 0; mem_wr = 0;
      if (VEC[i].rd)
        check($sformatf("R6/R7/R8 vec%0d read data", i), {8'h00, mem_rdata}, {8'h00, VEC[i].rdat});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule